// File: doc/BRIEF.md
# Blast and Bus-Inactivity Fault Controller

This block owns the fault status byte of a dual fan controller and the open-drain fault pull-down output. It overrides both 8-bit fan DAC codes with full scale whenever a blast event occurs. A blast has three sources: the blast input being high when power-on reset ends, a later falling edge on that input, or expiry of a bus-inactivity watchdog. The watchdog runs only while the blast input is high. Every time the device is addressed on its serial bus, the watchdog starts counting again.

The tach and GPIO fault flags are produced by neighbouring blocks. This block places them in the status byte unchanged and returns a fault-clear strobe to those blocks. When software writes the fault register, the blast and timer conditions are cleared and the written data is thrown away. The block is clocked from the 50 kHz oscillator timebase, so the default watchdog limit of 4,500,000 cycles is about 90 s.

Top module: `fan_blast_guard`

## Requirements
- R1: While `por_n` is low, `fault_byte` is 8'h00 and `fault_pd` is 1. The effective DAC codes equal the programmed codes until a blast occurs.
- R2: If `blast_pin` is high when `por_n` is released, bit 5 of `fault_byte` becomes set at the third rising clock edge after release. The first two edges fill a two-stage synchronizer.
- R3: After release, a high-to-low change of `blast_pin` sets bit 5 at the third rising edge after the change. Changes of `blast_pin` while `por_n` is low have no effect.
- R4: While bit 5 is set, `dac_a_eff` and `dac_b_eff` are both 8'hFF. Otherwise they follow `dac_a_prog` and `dac_b_prog` in the same cycle.
- R5: The watchdog counts only while the synchronized `blast_pin` is high, and it is reset to zero while that level is low. After WDOG_LIMIT consecutive counting edges with no `bus_hit`, bits 4 (timer) and 5 (blast) are both set and the count starts again.
- R6: `fault_byte` holds, from bit 7 down to bit 0: tach A fault (`tach_flt[1]`), tach B fault (`tach_flt[0]`), blast, timer, then GPIO4 to GPIO1 faults (`gpio_flt[3:0]`). Bits 7, 6 and 3 to 0 follow their inputs in the same cycle.
- R7: When `flt_wr` is high at a rising edge, bits 5 and 4 are cleared at that edge. `flt_clr` is high in exactly the cycles in which `flt_wr` is high.
- R8: A blast or timeout event at the same edge as `flt_wr` takes priority, so the affected bits stay set.
- R9: `fault_pd` is 1 whenever any bit of `fault_byte` is 1 or `por_n` is low, and 0 otherwise.
- R10: A `bus_hit` at the edge where the count would expire restarts the count and prevents the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 kHz timebase clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| blast_pin | input | 1 | Asynchronous blast and watchdog-gate input |
| bus_hit | input | 1 | One-cycle pulse when the device is addressed |
| flt_wr | input | 1 | Fault register write strobe |
| tach_flt | input | 2 | Tach fault flags, bit 1 = A, bit 0 = B |
| gpio_flt | input | 4 | GPIO fault flags, bit 3 = GPIO4 |
| dac_a_prog | input | 8 | Programmed DAC A code |
| dac_b_prog | input | 8 | Programmed DAC B code |
| dac_a_eff | output | 8 | Effective DAC A code |
| dac_b_eff | output | 8 | Effective DAC B code |
| fault_byte | output | 8 | Fault status byte |
| fault_pd | output | 1 | Fault pull-down enable |
| flt_clr | output | 1 | Fault-clear strobe to neighbouring blocks |

## Verification
A register write that clears the faults can land on the same edge as a blast trigger. The bench provokes this in two ways. First, it raises `flt_wr` for exactly the third edge after a falling `blast_pin`. Second, it holds `flt_wr` high across a whole watchdog period so that it covers a timeout edge. A second collision is a `bus_hit` on the exact edge where the watchdog would expire; the bench forces this with an access period equal to the limit, and also runs one period longer. In every cycle, a behavioural model applies set-over-clear and hit-over-expiry and judges the outputs against them.

// File: rtl/fan_blast_guard.sv
module fan_blast_guard #(
  parameter int WDOG_LIMIT = 4500000,
  parameter int CODE_W     = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              blast_pin,
  input  logic              bus_hit,
  input  logic              flt_wr,
  input  logic [1:0]        tach_flt,
  input  logic [3:0]        gpio_flt,
  input  logic [CODE_W-1:0] dac_a_prog,
  input  logic [CODE_W-1:0] dac_b_prog,
  output logic [CODE_W-1:0] dac_a_eff,
  output logic [CODE_W-1:0] dac_b_eff,
  output logic [7:0]        fault_byte,
  output logic              fault_pd,
  output logic              flt_clr
);
  localparam int CW = (WDOG_LIMIT > 2) ? $clog2(WDOG_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(WDOG_LIMIT - 1);
  localparam logic [CODE_W-1:0] FULL = '1;

  logic          sync1, sync2, prev;
  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          blast_st, timer_st;

  wire lvl_hit   = (st == 2'd2) & sync2;
  wire fall_hit  = (&st) & prev & ~sync2;
  wire wd_active = st[1] & sync2;
  wire wd_expire = wd_active & ~bus_hit & (cnt == LAST);
  wire set_blast = lvl_hit | fall_hit | wd_expire;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
      st    <= 2'd0;
    end else begin
      sync1 <= blast_pin;
      sync2 <= sync1;
      prev  <= sync2;
      if (st != 2'd3) st <= st + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt <= '0;
    else if (!wd_active || bus_hit || wd_expire) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      blast_st <= 1'b0;
      timer_st <= 1'b0;
    end else begin
      blast_st <= set_blast | (blast_st & ~flt_wr);
      timer_st <= wd_expire | (timer_st & ~flt_wr);
    end
  end

  assign dac_a_eff  = blast_st ? FULL : dac_a_prog;
  assign dac_b_eff  = blast_st ? FULL : dac_b_prog;
  assign fault_byte = {tach_flt, blast_st, timer_st, gpio_flt};
  assign fault_pd   = ~por_n | (|fault_byte);
  assign flt_clr    = flt_wr;

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (flt_wr && !set_blast) |=> !blast_st);
  // R5
  timer_blast_chk: assert property (@(posedge clk) disable iff (!por_n)
    timer_st |-> blast_st);
  // R5
  timer_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(timer_st) |-> $past(wd_active));
  // R3
  fall_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((&st) && prev && !sync2) |=> blast_st);
  // R9
  pd_chk: assert property (@(posedge clk) disable iff (!por_n)
    (|fault_byte) |-> fault_pd);
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    cnt <= LAST);
  // R10
  hit_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    bus_hit |=> (cnt == '0));
endmodule

// File: tb/fan_blast_guard_test.sv
module fan_blast_guard_test;
  localparam int LIM = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por_n = 1'b0, blast_pin = 1'b0, bus_hit = 1'b0, flt_wr = 1'b0;
  logic [1:0] tach_flt = '0;
  logic [3:0] gpio_flt = '0;
  logic [7:0] dac_a_prog = 8'h3C, dac_b_prog = 8'hA5;
  logic [7:0] dac_a_eff, dac_b_eff, fault_byte;
  logic       fault_pd, flt_clr;

  fan_blast_guard #(.WDOG_LIMIT(LIM), .CODE_W(8)) uut (
    .clk(clk), .por_n(por_n), .blast_pin(blast_pin), .bus_hit(bus_hit),
    .flt_wr(flt_wr), .tach_flt(tach_flt), .gpio_flt(gpio_flt),
    .dac_a_prog(dac_a_prog), .dac_b_prog(dac_b_prog),
    .dac_a_eff(dac_a_eff), .dac_b_eff(dac_b_eff), .fault_byte(fault_byte),
    .fault_pd(fault_pd), .flt_clr(flt_clr));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  bit q[$];
  int k = 0, mcnt = 0;
  bit mb = 0, mt = 0;

  always @(posedge clk) begin
    bit lv, fl, act, to;
    if (!por_n) begin
      q.delete(); k = 0; mcnt = 0; mb = 0; mt = 0;
    end else begin
      q.push_front(blast_pin);
      if (q.size() > 4) void'(q.pop_back());
      k++;
      lv  = (k == 3) && q[2];
      fl  = (k >= 4) && q[3] && !q[2];
      act = (k >= 3) && q[2];
      to  = 0;
      if (act) begin
        if (bus_hit) mcnt = 0;
        else if (mcnt == LIM - 1) begin to = 1; mcnt = 0; end
        else mcnt++;
      end else mcnt = 0;
      mb = (mb && !flt_wr) || lv || fl || to;
      mt = (mt && !flt_wr) || to;
    end
    #1;
    chk("R6 status byte", fault_byte, {tach_flt, mb, mt, gpio_flt});
    chk("R4 dac a", dac_a_eff, mb ? 8'hFF : dac_a_prog);
    chk("R4 dac b", dac_b_eff, mb ? 8'hFF : dac_b_prog);
    chk("R9 pull-down", {7'b0, fault_pd},
        {7'b0, (!por_n) || mb || mt || (|tach_flt) || (|gpio_flt)});
    chk("R7 clear strobe", {7'b0, flt_clr}, {7'b0, flt_wr});
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hits(int pulses, int period);
    for (int i = 0; i < pulses; i++) begin
      bus_hit = 1'b1; cyc(1); bus_hit = 1'b0; cyc(period - 1);
    end
  endtask

  task automatic clear_all();
    flt_wr = 1'b1; cyc(1); flt_wr = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R1 reset byte", fault_byte, 8'h00);
    chk("R1 reset pull-down", {7'b0, fault_pd}, 8'h01);
    por_n = 1'b1;
    cyc(5);
    chk("R1 dac a follows", dac_a_eff, 8'h3C);
    chk("R9 idle pull-down off", {7'b0, fault_pd}, 8'h00);

    gpio_flt = 4'b1010; tach_flt = 2'b01; cyc(2);
    chk("R6 layout", fault_byte, 8'h4A);
    tach_flt = 2'b10; gpio_flt = 4'b0101; cyc(1);
    chk("R6 layout b", fault_byte, 8'h85);
    tach_flt = '0; gpio_flt = '0; cyc(1);

    // R10: accesses exactly every LIM cycles never time out
    blast_pin = 1'b1; cyc(1);
    hits(8, LIM);
    chk("R10 no timeout", fault_byte, 8'h00);

    // R3 falling edge
    bus_hit = 1'b1; blast_pin = 1'b0; cyc(1); bus_hit = 1'b0; cyc(1);
    chk("R3 not yet", fault_byte, 8'h00);
    cyc(1);
    chk("R3 blast set", fault_byte, 8'h20);
    chk("R4 full scale", dac_b_eff, 8'hFF);
    dac_a_prog = 8'h80; cyc(2);
    chk("R4 still full", dac_a_eff, 8'hFF);
    clear_all();
    chk("R7 cleared", fault_byte, 8'h00);
    chk("R4 back", dac_a_eff, 8'h80);

    // R5 timeout
    blast_pin = 1'b1; cyc(LIM + 5);
    chk("R5 timeout", fault_byte, 8'h30);
    clear_all();

    // R8: clear on the same edge as a falling-edge blast
    blast_pin = 1'b0; cyc(2);
    flt_wr = 1'b1; cyc(1); flt_wr = 1'b0;
    chk("R8 set wins", fault_byte[5:5], 8'h01);
    clear_all();

    // R8: clear held across a timeout edge
    blast_pin = 1'b1; flt_wr = 1'b1; cyc(2 * LIM + 5); flt_wr = 1'b0;
    clear_all();

    // access period one longer than the limit
    hits(4, LIM + 1);
    clear_all();

    // R3: edges during reset are ignored
    por_n = 1'b0; cyc(2); blast_pin = 1'b0; cyc(2); por_n = 1'b1; cyc(5);
    chk("R3 ignored in reset", fault_byte, 8'h00);

    // R2: pin high at release
    por_n = 1'b0; blast_pin = 1'b1; cyc(3); por_n = 1'b1; cyc(2);
    chk("R2 not yet", fault_byte, 8'h00);
    cyc(1);
    chk("R2 level blast", fault_byte, 8'h20);
    hits(3, 5);
    clear_all();

    for (int i = 0; i < 600; i++) begin
      blast_pin  = ($urandom % 8) != 0 ? blast_pin : ~blast_pin;
      bus_hit    = ($urandom % 9) == 0;
      flt_wr     = ($urandom % 13) == 0;
      tach_flt   = 2'($urandom);
      gpio_flt   = 4'($urandom);
      dac_a_prog = 8'($urandom);
      dac_b_prog = 8'($urandom);
      if (($urandom % 150) == 0) por_n = 1'b0; else por_n = 1'b1;
      cyc(1);
    end
    bus_hit = 1'b0; flt_wr = 1'b0; por_n = 1'b1;
    cyc(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule